// File: doc/BRIEF.md
# Configurable GPIO Port Controller

This block controls one bidirectional port of `NUM_PINS` pins. Each pin has three stored bits: direction, option and data. Together the three bits pick the pin's mode, so there is no separate mode field. The data bit of an input pin chooses among the input sub-modes. The data bit of an output pin is the level the pin drives.

A small register bus reads and writes the data, direction and option registers, plus an interrupt control word. Each pin drives five signals toward its pad: an output enable, an output value, a pull-up request, an analog-select line and an interrupt request. Pin inputs pass through a two-flop synchronizer. The synchronized levels feed the edge detectors and the data register read path. Pins in interrupt mode share one sense setting: low level, falling edge or rising edge. Their requests are ORed into one port interrupt. An edge event stays latched until software writes the clear strobe.

Top module: `pin_mode_port`

## Requirements
- R1: After reset all three port registers and the sense field read as 0. Every pin has output enable 0, pull-up 1, analog-select 0 and interrupt request 0.
- R2: Mode bits (direction,option,data) = 001 make a floating input: output enable 0, pull-up 0, analog-select 0, no interrupt.
- R3: Mode bits 000 make an input with pull-up and no interrupt. Mode bits 010 make an input with pull-up that takes part in the port interrupt.
- R4: Mode bits 011 make an analog input: analog-select 1, pull-up 0, output enable 0, no interrupt, and the pin reads back 0 in the data register whatever its level.
- R5: Mode bits 10x make an open-drain output: the output value is 0, and the output enable is 1 when the data bit is 0 and 0 when it is 1.
- R6: Mode bits 11x make a push-pull output: output enable 1 and the output value equal to the data bit.
- R7: Bus address 0 is data, 1 is direction, 2 is option, 3 is interrupt control. The control word has sense in bits [1:0] and a write-only clear strobe in bit 2. A data read returns the stored data bit for output pins and the synchronized pin level for non-analog input pins. The pin level is visible two clock edges after the pin changes. Other registers read back what was written.
- R8: Sense 00 is low-level: an interrupt-mode pin requests while its synchronized level is 0, and stops as soon as it goes high.
- R9: Sense 01 is falling-edge: a 1-to-0 transition on an interrupt-mode pin sets a request that stays set after the pin returns high.
- R10: Sense 10 and 11 are rising-edge: a 0-to-1 transition on an interrupt-mode pin sets a latched request, and a falling transition does not.
- R11: The port interrupt is the OR of the per-pin requests. A pin that is not in interrupt mode never requests, whatever its level does.
- R12: Writing control with bit 2 set clears every latched edge request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_addr_i | input | 2 | Register select |
| reg_we_i | input | 1 | Write strobe |
| reg_wdata_i | input | NUM_PINS | Write data |
| reg_rdata_o | output | NUM_PINS | Read data for the selected register |
| pin_i | input | NUM_PINS | Pad input levels |
| pin_oe_o | output | NUM_PINS | Pad output enable |
| pin_out_o | output | NUM_PINS | Pad output value |
| pin_pu_o | output | NUM_PINS | Pull-up request |
| pin_ana_o | output | NUM_PINS | Analog-select |
| pin_irq_o | output | NUM_PINS | Per-pin interrupt request |
| irq_o | output | 1 | Port interrupt |

## Verification
The random part of the bench sweeps every direction, option and data combination against random pad levels. This exposes a decoder that swaps open-drain and push-pull polarity, or leaves the pull-up on for an analog pin. It also exposes a read path that returns the stored bit for an input pin, or the raw pad level for an analog pin. Directed cases check that an edge request stays set after the pad returns to its idle level, and that it drops only on the clear strobe. They also check that a falling edge is ignored under rising sense, and that sense code 11 behaves as rising. A final case toggles a pad whose pin is not in interrupt mode. A design that latched edges regardless of mode would raise the port interrupt there.

// File: rtl/pin_mode_pkg.sv
package pin_mode_pkg;
  localparam int REG_ADDR_W  = 2;
  localparam int CFG_CLR_BIT = 2;

  typedef enum logic [1:0] {
    ADDR_DATA   = 2'd0,
    ADDR_DIR    = 2'd1,
    ADDR_OPT    = 2'd2,
    ADDR_IRQCFG = 2'd3
  } reg_addr_e;

  typedef enum logic [1:0] {
    SENSE_LEVEL    = 2'd0,
    SENSE_FALL     = 2'd1,
    SENSE_RISE     = 2'd2,
    SENSE_RISE_ALT = 2'd3
  } sense_e;

  typedef enum logic [2:0] {
    MODE_IN_PU,
    MODE_IN_FLOAT,
    MODE_IN_IRQ,
    MODE_ANALOG,
    MODE_OPEN_DRAIN,
    MODE_PUSH_PULL
  } pin_mode_e;

  function automatic pin_mode_e decode_mode(input logic dir, input logic opt, input logic dat);
    pin_mode_e m;
    case ({dir, opt, dat})
      3'b000:          m = MODE_IN_PU;
      3'b001:          m = MODE_IN_FLOAT;
      3'b010:          m = MODE_IN_IRQ;
      3'b011:          m = MODE_ANALOG;
      3'b100, 3'b101:  m = MODE_OPEN_DRAIN;
      default:         m = MODE_PUSH_PULL;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int          WIDTH     = 8,
  parameter logic        RESET_VAL = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= {WIDTH{RESET_VAL}};
      sync_q <= {WIDTH{RESET_VAL}};
    end else begin
      meta_q <= async_i;
      sync_q <= meta_q;
    end
  end

  assign sync_o = sync_q;

  AST_SYNC_TWO_STAGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $stable(meta_q) |=> sync_q == $past(meta_q)) else $error("sync stage mismatch"); // R7
endmodule

// File: rtl/port_regs.sv
module port_regs import pin_mode_pkg::*; #(
  parameter int NUM_PINS = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [REG_ADDR_W-1:0] addr_i,
  input  logic                  we_i,
  input  logic [NUM_PINS-1:0]   wdata_i,
  input  logic [NUM_PINS-1:0]   pin_rd_i,
  output logic [NUM_PINS-1:0]   rdata_o,
  output logic [NUM_PINS-1:0]   dir_o,
  output logic [NUM_PINS-1:0]   opt_o,
  output logic [NUM_PINS-1:0]   dat_o,
  output sense_e                sense_o,
  output logic                  clr_o
);
  localparam int PAD_W = NUM_PINS - 2;

  logic [NUM_PINS-1:0] dir_q, opt_q, dat_q;
  sense_e              sense_q;
  reg_addr_e           addr;

  assign addr = reg_addr_e'(addr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q   <= '0;
      opt_q   <= '0;
      dat_q   <= '0;
      sense_q <= SENSE_LEVEL;
    end else if (we_i) begin
      case (addr)
        ADDR_DATA:   dat_q   <= wdata_i;
        ADDR_DIR:    dir_q   <= wdata_i;
        ADDR_OPT:    opt_q   <= wdata_i;
        default:     sense_q <= sense_e'(wdata_i[1:0]);
      endcase
    end
  end

  assign clr_o = we_i && (addr == ADDR_IRQCFG) && wdata_i[CFG_CLR_BIT];

  always_comb begin
    case (addr)
      ADDR_DATA: rdata_o = pin_rd_i;
      ADDR_DIR:  rdata_o = dir_q;
      ADDR_OPT:  rdata_o = opt_q;
      default:   rdata_o = {{PAD_W{1'b0}}, sense_q};
    endcase
  end

  assign dir_o   = dir_q;
  assign opt_o   = opt_q;
  assign dat_o   = dat_q;
  assign sense_o = sense_q;

  AST_DIR_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr == ADDR_DIR) |=> dir_q == $past(wdata_i)) else $error("dir write lost"); // R7
  AST_OPT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && addr == ADDR_OPT) |=> $stable(opt_q)) else $error("opt changed without write"); // R7
endmodule

// File: rtl/pin_cell.sv
module pin_cell import pin_mode_pkg::*; (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   dir_i,
  input  logic   opt_i,
  input  logic   dat_i,
  input  logic   sync_i,
  input  sense_e sense_i,
  input  logic   clr_i,
  output logic   oe_o,
  output logic   out_o,
  output logic   pu_o,
  output logic   ana_o,
  output logic   rd_o,
  output logic   irq_o
);
  pin_mode_e mode;
  logic      int_mode, edge_sense, hit;
  logic      prev_q, flag_q;

  assign mode = decode_mode(dir_i, opt_i, dat_i);

  always_comb begin
    oe_o     = 1'b0;
    out_o    = 1'b0;
    pu_o     = 1'b0;
    ana_o    = 1'b0;
    int_mode = 1'b0;
    rd_o     = sync_i;
    case (mode)
      MODE_IN_PU:      pu_o = 1'b1;
      MODE_IN_FLOAT:   ;
      MODE_IN_IRQ:     begin pu_o = 1'b1; int_mode = 1'b1; end
      MODE_ANALOG:     begin ana_o = 1'b1; rd_o = 1'b0; end
      MODE_OPEN_DRAIN: begin oe_o = ~dat_i; rd_o = dat_i; end
      default:         begin oe_o = 1'b1; out_o = dat_i; rd_o = dat_i; end
    endcase
  end

  assign edge_sense = (sense_i != SENSE_LEVEL);
  assign hit = (sense_i == SENSE_FALL) ? (prev_q & ~sync_i) : (~prev_q & sync_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b1;
      flag_q <= 1'b0;
    end else begin
      prev_q <= sync_i;
      // a new edge wins over a clear in the same cycle
      flag_q <= int_mode & edge_sense & ((flag_q & ~clr_i) | hit);
    end
  end

  assign irq_o = edge_sense ? flag_q : (int_mode & ~sync_i);

  AST_OE_ONLY_OUTPUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_o |-> dir_i) else $error("oe on input pin"); // R5
  AST_PU_ONLY_INPUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pu_o |-> (!dir_i && !ana_o)) else $error("pull-up on output or analog"); // R3
  AST_ANA_ISOLATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ana_o |-> (!oe_o && !irq_o && !rd_o)) else $error("analog pin not isolated"); // R4
  AST_OD_NEVER_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dir_i && !opt_i && oe_o) |-> !out_o) else $error("open-drain drives high"); // R5
  AST_EDGE_LATCHED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int_mode && edge_sense && flag_q && !clr_i) |=> (irq_o || sense_i == SENSE_LEVEL))
    else $error("latched edge lost"); // R9
  AST_NO_IRQ_OUTSIDE_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!int_mode ##1 !int_mode) |-> !irq_o) else $error("irq from non-irq pin"); // R11
endmodule

// File: rtl/pin_mode_port.sv
module pin_mode_port import pin_mode_pkg::*; #(
  parameter int NUM_PINS = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [REG_ADDR_W-1:0] reg_addr_i,
  input  logic                  reg_we_i,
  input  logic [NUM_PINS-1:0]   reg_wdata_i,
  output logic [NUM_PINS-1:0]   reg_rdata_o,
  input  logic [NUM_PINS-1:0]   pin_i,
  output logic [NUM_PINS-1:0]   pin_oe_o,
  output logic [NUM_PINS-1:0]   pin_out_o,
  output logic [NUM_PINS-1:0]   pin_pu_o,
  output logic [NUM_PINS-1:0]   pin_ana_o,
  output logic [NUM_PINS-1:0]   pin_irq_o,
  output logic                  irq_o
);
  logic [NUM_PINS-1:0] dir, opt, dat, sync, rd;
  sense_e              sense;
  logic                clr;

  port_regs #(.NUM_PINS(NUM_PINS)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .addr_i   (reg_addr_i),
    .we_i     (reg_we_i),
    .wdata_i  (reg_wdata_i),
    .pin_rd_i (rd),
    .rdata_o  (reg_rdata_o),
    .dir_o    (dir),
    .opt_o    (opt),
    .dat_o    (dat),
    .sense_o  (sense),
    .clr_o    (clr)
  );

  pin_sync #(.WIDTH(NUM_PINS), .RESET_VAL(1'b1)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (pin_i),
    .sync_o  (sync)
  );

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    pin_cell u_cell (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .dir_i   (dir[g]),
      .opt_i   (opt[g]),
      .dat_i   (dat[g]),
      .sync_i  (sync[g]),
      .sense_i (sense),
      .clr_i   (clr),
      .oe_o    (pin_oe_o[g]),
      .out_o   (pin_out_o[g]),
      .pu_o    (pin_pu_o[g]),
      .ana_o   (pin_ana_o[g]),
      .rd_o    (rd[g]),
      .irq_o   (pin_irq_o[g])
    );
  end

  assign irq_o = |pin_irq_o;

  AST_RESET_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (pin_oe_o == '0 && pin_ana_o == '0 && !irq_o)) else $error("not quiet after reset"); // R1
endmodule

// File: tb/pin_mode_port_bench.sv
`timescale 1ns/1ps
module pin_mode_port_bench;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [1:0]   addr = '0;
  logic         we = 1'b0;
  logic [N-1:0] wdata = '0;
  logic [N-1:0] rdata;
  logic [N-1:0] pins = '1;
  logic [N-1:0] oe, outv, pu, ana, pirq;
  logic         irq;
  int           checks = 0;
  int           errors = 0;

  always #2.5 clk = ~clk;

  pin_mode_port #(.NUM_PINS(N)) u_pin_mode_port (
    .clk_i(clk), .rst_ni(rst_n), .reg_addr_i(addr), .reg_we_i(we),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .pin_i(pins),
    .pin_oe_o(oe), .pin_out_o(outv), .pin_pu_o(pu), .pin_ana_o(ana),
    .pin_irq_o(pirq), .irq_o(irq)
  );

  function automatic logic [N-1:0] f_oe(logic [N-1:0] d, o, v);  return d & (o | ~v); endfunction
  function automatic logic [N-1:0] f_out(logic [N-1:0] d, o, v); return d & o & v; endfunction
  function automatic logic [N-1:0] f_pu(logic [N-1:0] d, o, v);  return ~d & ~v; endfunction
  function automatic logic [N-1:0] f_ana(logic [N-1:0] d, o, v); return ~d & o & v; endfunction
  function automatic logic [N-1:0] f_int(logic [N-1:0] d, o, v); return ~d & o & ~v; endfunction
  function automatic logic [N-1:0] f_rd(logic [N-1:0] d, o, v, p);
    return (d & v) | (~d & ~(o & v) & p);
  endfunction

  task automatic chk(input string req, input logic [N-1:0] got, input logic [N-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [N-1:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [N-1:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic set_mode(input logic [N-1:0] d, o, v);
    wr(2'd1, d); wr(2'd2, o); wr(2'd0, v);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [N-1:0] r, d, o, v, p;
    void'($urandom(32'h1d2c));
    tick(3);
    rst_n = 1'b1;
    tick(2);

    // R1 reset state
    rd(2'd0, r); chk("R1 data read (pins high)", r, '1);
    rd(2'd1, r); chk("R1 dir", r, '0);
    rd(2'd2, r); chk("R1 opt", r, '0);
    rd(2'd3, r); chk("R1 sense", r, '0);
    chk("R1 oe", oe, '0);
    chk("R1 pu", pu, '1);
    chk("R1 ana", ana, '0);
    chk("R1 irq", {pirq[N-1:1], irq}, '0);

    // random sweep, level sense; R2 R3 R4 R5 R6 R7 R8 R11
    for (int i = 0; i < 60; i++) begin
      d = N'($urandom); o = N'($urandom); v = N'($urandom); p = N'($urandom);
      pins = p;
      set_mode(d, o, v);
      tick(3);
      chk("R5 R6 oe", oe, f_oe(d, o, v));
      chk("R5 R6 out", outv, f_out(d, o, v));
      chk("R2 R3 pu", pu, f_pu(d, o, v));
      chk("R4 ana", ana, f_ana(d, o, v));
      chk("R8 level irq", pirq, f_int(d, o, v) & ~p);
      chk("R11 port irq", {7'd0, irq}, {7'd0, |(f_int(d, o, v) & ~p)});
      rd(2'd0, r); chk("R7 data read", r, f_rd(d, o, v, p));
      rd(2'd1, r); chk("R7 dir read", r, d);
    end

    // R4 analog pin reads 0 while pad high
    pins = '1;
    set_mode(8'h00, 8'h01, 8'h01);
    tick(3);
    rd(2'd0, r); chk("R4 analog read", r, 8'hFE);

    // pin0 in interrupt mode, others input with pull-up
    set_mode(8'h00, 8'h01, 8'h00);
    wr(2'd3, 8'h05); // falling + clear
    tick(3);
    chk("R9 idle", pirq, '0);
    pins[0] = 1'b0; tick(5);
    chk("R9 fall set", pirq, 8'h01);
    pins[0] = 1'b1; tick(5);
    chk("R9 latched after return", pirq, 8'h01);
    chk("R11 port irq latched", {7'd0, irq}, 8'h01);
    wr(2'd3, 8'h05); tick(2);
    chk("R12 clear", pirq, '0);

    // R10 rising
    wr(2'd3, 8'h06); tick(2);
    pins[0] = 1'b0; tick(5);
    chk("R10 fall ignored", pirq, '0);
    pins[0] = 1'b1; tick(5);
    chk("R10 rise set", pirq, 8'h01);
    wr(2'd3, 8'h07); tick(2);
    chk("R12 clear rising", pirq, '0);
    pins[0] = 1'b0; tick(5);
    pins[0] = 1'b1; tick(5);
    chk("R10 sense 11 rising", pirq, 8'h01);
    wr(2'd3, 8'h07); tick(2);

    // R11 non-interrupt pin toggles
    pins[3] = 1'b0; tick(5);
    pins[3] = 1'b1; tick(5);
    chk("R11 non-irq pin", {7'd0, irq}, '0);

    // R8 level follows pad, not latched
    wr(2'd3, 8'h00);
    pins[0] = 1'b0; tick(4);
    chk("R8 level low", pirq, 8'h01);
    pins[0] = 1'b1; tick(4);
    chk("R8 level released", pirq, '0);

    // R3 mode 000 with pad low gives no request
    set_mode(8'h00, 8'h00, 8'h00);
    pins = '0; tick(4);
    chk("R3 no irq in 000", {7'd0, irq}, '0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule